// File: doc/BRIEF.md
# Checkpointed Register File with Rollback

This block is a small general-purpose register file built for speculative execution. Every architectural register exists twice: a working copy, which the read and write ports see, and a hidden committed copy. Speculative code runs against the working copies only, so a region of work can be tried without losing the last known good state.

Two single-cycle controls manage the committed copies. A commit pulse makes the whole speculative region permanent: every working value is copied into its committed copy at one clock edge. A rollback pulse discards the region: every working register is reloaded from its committed copy at one clock edge. This returns the file to the state it had at the end of the previous region. The logic that detects faults and decides when to commit or roll back sits outside this block.

Top module: `ckpt_rf`

## Requirements
- R1: After reset (active-low, asynchronous) every working copy and every committed copy is zero; reads return zero, and a rollback straight after reset also leaves every register at zero.
- R2: The two read ports are combinational. Each returns the working copy of the register selected by its own 4-bit address, with no clock delay.
- R3: When wr_en_i is high at a clock edge, the working copy of the register at wr_addr_i takes wr_data_i. All other working copies keep their values. The new value is readable after that edge.
- R4: An ordinary write does not change any committed copy. A later rollback returns the value committed before the write.
- R5: A commit (commit_i high, rollback_i low) copies all 16 working values into their committed copies at one edge.
- R6: A rollback reloads all 16 working copies from their committed copies at one edge. A read in the following cycle returns the restored value.
- R7: When a write and a commit fall in the same cycle, the written value lands in both the working copy and the committed copy of that register.
- R8: When commit and rollback are both high, rollback takes effect and the commit is ignored. The committed copies keep their prior values.
- R9: Any write in a rollback cycle is discarded: the working copy ends up equal to its committed copy.
- R10: With wr_en_i low, wr_addr_i and wr_data_i have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_addr_a_i | input | 4 | Read port A register select |
| rd_data_a_o | output | 32 | Read port A working value |
| rd_addr_b_i | input | 4 | Read port B register select |
| rd_data_b_o | output | 32 | Read port B working value |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 4 | Write register select |
| wr_data_i | input | 32 | Write data |
| commit_i | input | 1 | Copy all working values into committed copies |
| rollback_i | input | 1 | Reload all working values from committed copies |

## Verification
A distinct data pattern is written to all 16 registers. Both ports then read the registers in opposite address orders, which exposes address decode errors and ports that are swapped or tied together. The committed copies can only be seen through a rollback. Each scenario therefore writes, commits or overwrites, rolls back, and then reads every register. Because the overwritten values differ from the committed ones, the reads show whether a commit, a plain write or a discarded write touched the committed state. The combined cycles (write with commit, commit with rollback, write with rollback) use values that differ from every earlier one. This makes any mistake in the priority between the controls appear as a specific wrong word.

// File: rtl/ckpt_rf_pkg.sv
package ckpt_rf_pkg;
  parameter int unsigned CKPT_DW   = 32;
  parameter int unsigned CKPT_NREG = 16;

  typedef enum logic [1:0] {
    OP_HOLD     = 2'd0,
    OP_WRITE    = 2'd1,
    OP_COMMIT   = 2'd2,
    OP_ROLLBACK = 2'd3
  } ckpt_op_e;
endpackage

// File: rtl/ckpt_rf_ctrl.sv
module ckpt_rf_ctrl #(
  parameter int unsigned NREG = 16,
  parameter int unsigned AW   = $clog2(NREG)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic                 commit_i,
  input  logic                 rollback_i,
  output logic [NREG-1:0]      we_vec_o,
  output logic                 commit_o,
  output logic                 rollback_o,
  output ckpt_rf_pkg::ckpt_op_e op_o
);
  import ckpt_rf_pkg::*;

  logic [NREG-1:0] dec;

  always_comb begin
    dec = '0;
    for (int i = 0; i < NREG; i++) begin
      dec[i] = (wr_addr_i == AW'(i));
    end
  end

  // rollback has top priority: it masks both the write and the commit
  assign rollback_o = rollback_i;
  assign commit_o   = commit_i & ~rollback_i;
  assign we_vec_o   = (wr_en_i & ~rollback_i) ? dec : '0;

  always_comb begin
    if (rollback_i)    op_o = OP_ROLLBACK;
    else if (commit_i) op_o = OP_COMMIT;
    else if (wr_en_i)  op_o = OP_WRITE;
    else               op_o = OP_HOLD;
  end

  p_onehot_we_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we_vec_o));
  p_rb_blocks_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rollback_i |-> ($countones(we_vec_o) == 0));
  p_rb_blocks_commit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rollback_i |-> !commit_o);
endmodule

// File: rtl/ckpt_rf_cell.sv
module ckpt_rf_cell #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          commit_i,
  input  logic          rollback_i,
  output logic [DW-1:0] work_o,
  output logic [DW-1:0] shadow_o
);
  logic [DW-1:0] work_q, shadow_q;
  logic [DW-1:0] work_next;

  assign work_next = we_i ? wdata_i : work_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         work_q <= '0;
    else if (rollback_i) work_q <= shadow_q;
    else                 work_q <= work_next;
  end

  // commit captures the post-write value so a same-cycle write is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       shadow_q <= '0;
    else if (commit_i) shadow_q <= work_next;
  end

  assign work_o   = work_q;
  assign shadow_o = shadow_q;

  p_restore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rollback_i |=> (work_q == $past(shadow_q)));
  p_write_keeps_shadow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !commit_i) |=> $stable(shadow_q));
  p_commit_copy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !we_i) |=> (shadow_q == $past(work_q)));
  p_write_commit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && we_i) |=> (shadow_q == $past(wdata_i) && work_q == shadow_q));
  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !commit_i && !rollback_i) |=> ($stable(work_q) && $stable(shadow_q)));
endmodule

// File: rtl/ckpt_rf_rdport.sv
module ckpt_rf_rdport #(
  parameter int unsigned DW   = 32,
  parameter int unsigned NREG = 16,
  parameter int unsigned AW   = $clog2(NREG)
) (
  input  logic [NREG-1:0][DW-1:0] regs_i,
  input  logic [AW-1:0]           addr_i,
  output logic [DW-1:0]           data_o
);
  always_comb begin
    data_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (addr_i == AW'(i)) data_o = regs_i[i];
    end
  end

  always_comb begin
    p_read_select_r2: assert (data_o == regs_i[addr_i]);
  end
endmodule

// File: rtl/ckpt_rf.sv
module ckpt_rf #(
  parameter int unsigned DW   = ckpt_rf_pkg::CKPT_DW,
  parameter int unsigned NREG = ckpt_rf_pkg::CKPT_NREG,
  parameter int unsigned AW   = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd_addr_a_i,
  output logic [DW-1:0] rd_data_a_o,
  input  logic [AW-1:0] rd_addr_b_i,
  output logic [DW-1:0] rd_data_b_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          commit_i,
  input  logic          rollback_i
);
  import ckpt_rf_pkg::*;

  localparam int unsigned NPORT = 2;

  logic [NREG-1:0]          we_vec;
  logic                     commit_g, rollback_g;
  ckpt_op_e                 op;
  logic [NREG-1:0][DW-1:0]  work, shadow;
  logic [NPORT-1:0][AW-1:0] rd_addr;
  logic [NPORT-1:0][DW-1:0] rd_data;

  ckpt_rf_ctrl #(.NREG(NREG), .AW(AW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .commit_i   (commit_i),
    .rollback_i (rollback_i),
    .we_vec_o   (we_vec),
    .commit_o   (commit_g),
    .rollback_o (rollback_g),
    .op_o       (op)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_cell
    ckpt_rf_cell #(.DW(DW)) u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .we_i       (we_vec[g]),
      .wdata_i    (wr_data_i),
      .commit_i   (commit_g),
      .rollback_i (rollback_g),
      .work_o     (work[g]),
      .shadow_o   (shadow[g])
    );
  end

  assign rd_addr[0] = rd_addr_a_i;
  assign rd_addr[1] = rd_addr_b_i;

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    ckpt_rf_rdport #(.DW(DW), .NREG(NREG), .AW(AW)) u_rd (
      .regs_i (work),
      .addr_i (rd_addr[p]),
      .data_o (rd_data[p])
    );
  end

  assign rd_data_a_o = rd_data[0];
  assign rd_data_b_o = rd_data[1];

  p_rb_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_ROLLBACK) |=> (work == $past(shadow) && shadow == $past(shadow)));
  p_reset_zero_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (work == '0 && shadow == '0));
endmodule

// File: tb/ckpt_rf_bench.sv
module ckpt_rf_bench;
  localparam int CLK_PERIOD = 100;
  localparam int NREG = 16;
  localparam int DW   = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    ra_a = '0, ra_b = '0, wa = '0;
  logic [DW-1:0] rd_a, rd_b, wd = '0;
  logic          we = 1'b0, cm = 1'b0, rb = 1'b0;

  logic [DW-1:0] m_work   [NREG];
  logic [DW-1:0] m_shadow [NREG];

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ckpt_rf u_ckpt_rf (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rd_addr_a_i (ra_a),
    .rd_data_a_o (rd_a),
    .rd_addr_b_i (ra_b),
    .rd_data_b_o (rd_b),
    .wr_en_i     (we),
    .wr_addr_i   (wa),
    .wr_data_i   (wd),
    .commit_i    (cm),
    .rollback_i  (rb)
  );

  task automatic cmp(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock cycle with the given controls; model follows the requirements
  task automatic step(logic w, logic [3:0] a, logic [DW-1:0] d, logic c, logic r);
    @(negedge clk);
    we = w; wa = a; wd = d; cm = c; rb = r;
    @(posedge clk);
    if (r) begin
      for (int i = 0; i < NREG; i++) m_work[i] = m_shadow[i];   // R6 R8 R9
    end else begin
      if (w) m_work[a] = d;                                     // R3
      if (c) for (int i = 0; i < NREG; i++) m_shadow[i] = m_work[i]; // R5 R7
    end
  endtask

  task automatic check_all(string req);
    @(negedge clk);
    we = 1'b0; cm = 1'b0; rb = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      ra_a = 4'(i);
      ra_b = 4'(NREG - 1 - i);
      #2;
      cmp(req, rd_a, m_work[i]);
      cmp(req, rd_b, m_work[NREG-1-i]);
    end
  endtask

  task automatic t_reset;
    for (int i = 0; i < NREG; i++) begin m_work[i] = '0; m_shadow[i] = '0; end
    check_all("R1 reset");
    step(1'b0, 4'd0, '0, 1'b0, 1'b1);
    check_all("R1 rollback after reset");
  endtask

  task automatic t_write_read;
    for (int i = 0; i < NREG; i++) step(1'b1, 4'(i), 32'hA500_0000 | (32'(i) * 32'h1111), 1'b0, 1'b0);
    check_all("R2 R3 write pattern");
  endtask

  task automatic t_no_write;
    step(1'b0, 4'd5, 32'hDEAD_BEEF, 1'b0, 1'b0);
    step(1'b0, 4'd0, 32'hFFFF_FFFF, 1'b0, 1'b0);
    check_all("R10 enable low");
  endtask

  task automatic t_write_no_shadow;
    step(1'b0, 4'd0, '0, 1'b0, 1'b1);
    check_all("R4 shadow untouched by writes");
  endtask

  task automatic t_commit;
    for (int i = 0; i < NREG; i++) step(1'b1, 4'(i), 32'h3C00_0000 + 32'(i * 7), 1'b0, 1'b0);
    step(1'b0, 4'd0, '0, 1'b1, 1'b0);
    check_all("R5 after commit");
    step(1'b1, 4'd2, 32'h0BAD_0002, 1'b0, 1'b0);
    step(1'b1, 4'd15, 32'h0BAD_000F, 1'b0, 1'b0);
    check_all("R3 overwrite");
    step(1'b0, 4'd0, '0, 1'b0, 1'b1);
    check_all("R5 R6 restore committed");
  endtask

  task automatic t_write_commit;
    step(1'b1, 4'd7, 32'h7777_1234, 1'b1, 1'b0);
    step(1'b1, 4'd7, 32'h0000_5555, 1'b0, 1'b0);
    step(1'b0, 4'd0, '0, 1'b0, 1'b1);
    check_all("R7 write with commit");
  endtask

  task automatic t_commit_rollback;
    step(1'b1, 4'd3, 32'h1357_9BDF, 1'b0, 1'b0);
    step(1'b1, 4'd4, 32'h2468_ACE0, 1'b1, 1'b1);
    check_all("R8 rollback beats commit");
    step(1'b0, 4'd0, '0, 1'b0, 1'b1);
    check_all("R8 shadow kept");
  endtask

  task automatic t_write_rollback;
    step(1'b1, 4'd9, 32'hCAFE_0009, 1'b0, 1'b0);
    step(1'b1, 4'd9, 32'hF00D_0009, 1'b0, 1'b1);
    check_all("R9 write in rollback cycle");
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_write_read;
    t_no_write;
    t_write_no_shadow;
    t_commit;
    t_write_commit;
    t_commit_rollback;
    t_write_rollback;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule